// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational integer arithmetic/logic unit for two operands of a parameterised width (32 bits by default). The datapath is organised as a chain of identical one-bit cells. Each cell can complement either operand bit and forms an AND, an OR and a full-adder sum. A four-way selector then picks the cell's output from these three terms and a comparison input.

A four-bit operation code drives the block. A small decoder turns the code into per-cell strobes: complement A, complement B, which output term to pick, whether the operation is arithmetic, and whether the code is unsupported. Subtraction reuses the adder: B is complemented and the same strobe supplies the carry into the lowest cell. Set-less-than runs a subtraction and routes the corrected sign back into bit 0. NOR is the AND path with both operands complemented.

The block produces the result word, a zero indicator, a signed overflow flag and an unsigned carry flag. Results settle within the same cycle in which the inputs are applied.

Top module: `alu_bitslice`

## Requirements
- R1: Code 4'b0000 gives result = a & b.
- R2: Code 4'b0001 gives result = a | b.
- R3: Code 4'b0010 gives result = (a + b) modulo 2^WIDTH, and carryOut equals the carry out of the top bit of that sum.
- R4: Code 4'b0110 gives result = (a - b) modulo 2^WIDTH, computed as a + ~b + 1. carryOut is the carry out of the top bit of that sum, which is 1 exactly when a >= b as unsigned numbers.
- R5: Code 4'b0111 gives result = 1 when a < b as signed two's-complement numbers and 0 otherwise. This holds even when a - b overflows. All result bits above bit 0 are 0.
- R6: Code 4'b1100 gives result = ~(a | b).
- R7: zero is 1 exactly when every result bit is 0.
- R8: For codes 4'b0010 and 4'b0110, overflow is 1 exactly when the signed two's-complement sum or difference does not fit in WIDTH bits.
- R9: For codes 4'b0000, 4'b0001, 4'b0111 and 4'b1100, both overflow and carryOut are 0.
- R10: Any code outside the six listed gives a result of all zeros, with overflow and carryOut at 0 and zero at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| ctrlCode | input | 4 | Operation code {complement A, complement B, output select[1:0]} |
| result | output | WIDTH | Selected function of a and b |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |
| carryOut | output | 1 | Carry out of the top bit for add or subtract |

## Verification
Every output is combinational, so each result and flag is due in the same cycle in which its operands and code are applied, with no register on the way. The bench changes the inputs just after a rising edge and compares all four outputs at the following falling edge, half a period later and well clear of the next input change. The reference model computes sums, differences and signed comparisons with wide integer arithmetic, independent of the cell chain. Corner operands such as the most negative value, all ones and mixed signs stress the overflow and set-less-than correction.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam logic [3:0] CODE_AND = 4'b0000;
  localparam logic [3:0] CODE_OR  = 4'b0001;
  localparam logic [3:0] CODE_ADD = 4'b0010;
  localparam logic [3:0] CODE_SUB = 4'b0110;
  localparam logic [3:0] CODE_SLT = 4'b0111;
  localparam logic [3:0] CODE_NOR = 4'b1100;

  localparam logic [1:0] SEL_AND  = 2'b00;
  localparam logic [1:0] SEL_OR   = 2'b01;
  localparam logic [1:0] SEL_SUM  = 2'b10;
  localparam logic [1:0] SEL_LESS = 2'b11;

  typedef struct packed {
    logic       aInv;
    logic       bInv;
    logic [1:0] outSel;
    logic       arith;
    logic       kill;
  } alu_strobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0]  ctrlCode,
  output alu_strobe_t strobe
);

  always_comb begin
    strobe.aInv   = ctrlCode[3];
    strobe.bInv   = ctrlCode[2];
    strobe.outSel = ctrlCode[1:0];
    strobe.arith  = 1'b0;
    strobe.kill   = 1'b0;
    case (ctrlCode)
      CODE_AND, CODE_OR, CODE_SLT, CODE_NOR: ;
      CODE_ADD, CODE_SUB: strobe.arith = 1'b1;
      default: begin
        strobe.aInv   = 1'b0;
        strobe.bInv   = 1'b0;
        strobe.outSel = SEL_AND;
        strobe.kill   = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  alu_strobe_t      strobe,
  output logic [WIDTH-1:0] result,
  output logic             ovRaw,
  output logic             coutRaw
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] opA;
  logic [WIDTH-1:0] opB;
  logic [WIDTH-1:0] andBits;
  logic [WIDTH-1:0] orBits;
  logic [WIDTH-1:0] sumBits;
  logic [WIDTH:0]   carryChain;
  logic             lessBit;

  // cell-wise operand conditioning and logic terms
  assign opA     = a ^ {WIDTH{strobe.aInv}};
  assign opB     = b ^ {WIDTH{strobe.bInv}};
  assign andBits = opA & opB;
  assign orBits  = opA | opB;

  // ripple chain, evaluated cell by cell in one process
  always_comb begin
    carryChain    = '0;
    carryChain[0] = strobe.bInv;
    for (int i = 0; i < WIDTH; i++) begin
      sumBits[i]      = opA[i] ^ opB[i] ^ carryChain[i];
      carryChain[i+1] = (opA[i] & opB[i]) | (carryChain[i] & (opA[i] ^ opB[i]));
    end
  end

  assign coutRaw = carryChain[WIDTH];
  assign ovRaw   = (opA[MSB] == opB[MSB]) && (sumBits[MSB] != opA[MSB]);
  assign lessBit = sumBits[MSB] ^ ovRaw;

  // per-cell output selector
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      case (strobe.outSel)
        SEL_AND:  result[i] = andBits[i];
        SEL_OR:   result[i] = orBits[i];
        SEL_SUM:  result[i] = sumBits[i];
        default:  result[i] = (i == 0) ? lessBit : 1'b0;
      endcase
    end
    if (strobe.kill) result = '0;
  end

endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] result,
  input  logic             ovRaw,
  input  logic             coutRaw,
  input  logic             arith,
  output logic             zero,
  output logic             overflow,
  output logic             carryOut
);

  assign zero     = (result == '0);
  assign overflow = arith & ovRaw;
  assign carryOut = arith & coutRaw;

endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       ctrlCode,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow,
  output logic             carryOut
);

  alu_strobe_t strobe;
  logic        ovRaw;
  logic        coutRaw;

  alu_ctrl u_ctrl (
    .ctrlCode (ctrlCode),
    .strobe   (strobe)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .a       (a),
    .b       (b),
    .strobe  (strobe),
    .result  (result),
    .ovRaw   (ovRaw),
    .coutRaw (coutRaw)
  );

  alu_flags #(.WIDTH(WIDTH)) u_flags (
    .result   (result),
    .ovRaw    (ovRaw),
    .coutRaw  (coutRaw),
    .arith    (strobe.arith),
    .zero     (zero),
    .overflow (overflow),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/alu_bitslice_chk.sv
module alu_bitslice_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [3:0]       ctrlCode,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             overflow,
  input logic             carryOut
);

  logic known;
  assign known = !$isunknown({a, b, ctrlCode, result, zero, overflow, carryOut});

  always_comb begin
    if (known) begin
      p_zero_match_r7: assert (zero == (result == '0))
        else $error("zero flag disagrees with result");
      if (ctrlCode == 4'b0010) begin
        p_add_sum_r3: assert ({carryOut, result} == ({1'b0, a} + {1'b0, b}))
          else $error("add sum or carry wrong");
      end
      if (ctrlCode == 4'b0111) begin
        p_slt_upper_r5: assert (result[WIDTH-1:1] == '0)
          else $error("slt upper bits not clear");
      end
      if (ctrlCode == 4'b0000 || ctrlCode == 4'b0001 ||
          ctrlCode == 4'b0111 || ctrlCode == 4'b1100) begin
        p_no_flags_r9: assert (!overflow && !carryOut)
          else $error("arith flag set on non-arith code");
      end
      if (!(ctrlCode inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100})) begin
        p_bad_code_r10: assert (result == '0 && zero && !overflow && !carryOut)
          else $error("unsupported code not cleared");
      end
    end
  end

endmodule

bind alu_bitslice alu_bitslice_chk #(.WIDTH(WIDTH)) u_chk (
  .a        (a),
  .b        (b),
  .ctrlCode (ctrlCode),
  .result   (result),
  .zero     (zero),
  .overflow (overflow),
  .carryOut (carryOut)
);

// File: tb/tb_alu_bitslice.sv
module tb_alu_bitslice;

  localparam int WIDTH    = 32;
  localparam int CLK_HALF = 5;
  localparam int CLK_PER  = 2 * CLK_HALF;
  localparam int WATCHDOG = 150000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [WIDTH-1:0] a = '0;
  logic [WIDTH-1:0] b = '0;
  logic [3:0]       ctrlCode = 4'b0000;
  logic [WIDTH-1:0] result;
  logic             zero;
  logic             overflow;
  logic             carryOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_HALF) clk = ~clk;

  alu_bitslice #(.WIDTH(WIDTH)) dut (
    .a        (a),
    .b        (b),
    .ctrlCode (ctrlCode),
    .result   (result),
    .zero     (zero),
    .overflow (overflow),
    .carryOut (carryOut)
  );

  function automatic string resTag(input logic [3:0] code);
    case (code)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R10";
    endcase
  endfunction

  function automatic bit isArith(input logic [3:0] code);
    return code == 4'b0010 || code == 4'b0110;
  endfunction

  task automatic checkBit(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic runVec(input logic [3:0] code, input logic [WIDTH-1:0] va, input logic [WIDTH-1:0] vb);
    longint sa, sb, sr;
    logic [WIDTH:0]   wide;
    logic [WIDTH-1:0] expRes;
    logic             expOv, expCy;
    longint maxS, minS;
    maxS = (64'sd1 <<< (WIDTH-1)) - 1;
    minS = -(64'sd1 <<< (WIDTH-1));
    sa = longint'($signed(va));
    sb = longint'($signed(vb));
    expOv = 1'b0;
    expCy = 1'b0;
    case (code)
      4'b0000: expRes = va & vb;
      4'b0001: expRes = va | vb;
      4'b0010: begin
        wide = {1'b0, va} + {1'b0, vb};
        expRes = wide[WIDTH-1:0];
        expCy = wide[WIDTH];
        sr = sa + sb;
        expOv = (sr > maxS) || (sr < minS);
      end
      4'b0110: begin
        expRes = va - vb;
        expCy = (va >= vb);
        sr = sa - sb;
        expOv = (sr > maxS) || (sr < minS);
      end
      4'b0111: expRes = (sa < sb) ? 1 : 0;
      4'b1100: expRes = ~(va | vb);
      default: expRes = '0;
    endcase
    @(posedge clk);
    #1;
    a = va;
    b = vb;
    ctrlCode = code;
    @(negedge clk);
    checks++;
    if (result !== expRes) begin
      errors++;
      $display("FAIL %s result code=%b a=%h b=%h actual=%h expected=%h",
               resTag(code), code, va, vb, result, expRes);
    end
    checkBit("R7", "zero", zero, expRes == '0);
    checkBit(isArith(code) ? "R8" : (resTag(code) == "R10" ? "R10" : "R9"),
             "overflow", overflow, expOv);
    checkBit(code == 4'b0010 ? "R3" : (code == 4'b0110 ? "R4" :
             (resTag(code) == "R10" ? "R10" : "R9")), "carryOut", carryOut, expCy);
  endtask

  initial begin
    #(CLK_PER * WATCHDOG);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [WIDTH-1:0] corner [8];
    logic [3:0]       codes  [10];
    corner[0] = '0;
    corner[1] = 1;
    corner[2] = '1;
    corner[3] = {1'b0, {(WIDTH-1){1'b1}}};
    corner[4] = {1'b1, {(WIDTH-1){1'b0}}};
    corner[5] = {1'b1, {(WIDTH-2){1'b0}}, 1'b1};
    corner[6] = {(WIDTH/2){2'b10}};
    corner[7] = {(WIDTH/2){2'b01}};
    codes[0] = 4'b0000; codes[1] = 4'b0001; codes[2] = 4'b0010;
    codes[3] = 4'b0110; codes[4] = 4'b0111; codes[5] = 4'b1100;
    codes[6] = 4'b0011; codes[7] = 4'b1111; codes[8] = 4'b0100;
    codes[9] = 4'b1010;

    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // initial state: AND of zero operands (R1), zero flag set (R7)
    @(negedge clk);
    checkBit("R1", "initial result zero", result == '0, 1'b1);
    checkBit("R7", "initial zero", zero, 1'b1);
    checkBit("R9", "initial overflow", overflow, 1'b0);

    // R5 overflow-corrected comparison: most negative vs positive
    runVec(4'b0111, corner[4], 1);
    runVec(4'b0111, corner[3], corner[4]);
    // R8 overflow edges
    runVec(4'b0010, corner[3], 1);
    runVec(4'b0110, corner[4], 1);
    // R4 equal operands give carry 1 and zero result
    runVec(4'b0110, corner[6], corner[6]);

    for (int c = 0; c < 10; c++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          runVec(codes[c], corner[i], corner[j]);

    for (int n = 0; n < 300; n++)
      for (int c = 0; c < 10; c++)
        runVec(codes[c], $urandom, $urandom);

    for (int n = 0; n < 40; n++)
      runVec(4'(n), $urandom, $urandom);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule